// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision timer with a small register interface. A down-counter, `CNT_W` bits wide (12 by default), steps once for every pulse of a slow tick enable. With a 256 Hz tick the full count of 0xFFF lasts about 16 seconds. Software must restart the counter with a keyed command before it runs out. The restart is only legal once the counter has fallen into the window, that is, to or below a programmed delta. Restarting too early is treated as a fault, just like running out.

The configuration register can be written once after reset and is frozen from then on. It holds:
- the reload value and the window delta;
- routing for faults to an interrupt line, a reset request, or both;
- a processor-only reset qualifier;
- a disable bit;
- two halt enables that freeze the count while an idle or debug input is high.

Fault causes are latched in a status register that clears when it is read. Clock generation and the reset controller lie outside the block.

Top module: `winwdt`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control, write only), 0x4 (mode) and 0x8 (status). After reset, mode reads 0x3FFF2FFF, status reads 0, and `fault_irq`, `rst_req` and `rst_proc` are low.
- R2: Mode register fields are:
  - reload value at bits [11:0];
  - window delta at bits [27:16];
  - interrupt enable at bit 12;
  - reset enable at bit 13;
  - processor-only reset at bit 14;
  - disable at bit 15;
  - debug-halt enable at bit 28;
  - idle-halt enable at bit 29.

  Only the first mode write after reset is accepted, and it also loads the counter with the new reload value. Every later mode write is ignored, and the register keeps reading its first value.
- R3: Each tick decrements the counter. A tick that finds the counter at zero raises an underflow fault and reloads the reload value, so a timeout takes reload+1 ticks.
- R4: A control write with 0xA5 in bits [31:24] and bit 0 set is a restart, and it reloads the counter. A control write with any other key, or with bit 0 clear, has no effect.
- R5: A restart while the counter is greater than the window delta raises an error fault and still reloads the counter. A restart while the counter is equal to or below the delta is legal and raises no fault.
- R6: Status bit 0 latches underflow and bit 1 latches error. Both bits stay set until the status register is read, and that read clears them.
- R7: `fault_irq` is high while the interrupt enable is set and either status bit is set.
- R8: Every fault produces a one-cycle `rst_req` pulse when the reset enable is set, and no pulse when it is clear. `rst_proc` pulses together with `rst_req` only when the processor-only bit is set.
- R9: With the disable bit set, the counter does not move, restarts are ignored and no fault is raised.
- R10: While `dbg_in` is high and debug-halt is enabled, ticks do not move the counter. While `idle_in` is high and idle-halt is enabled, ticks likewise do not move it. An idle or debug input whose halt enable is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one cycle per timer step |
| idle_in | input | 1 | System idle indication |
| dbg_in | input | 1 | Debugger halt indication |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| fault_irq | output | 1 | Fault interrupt, level |
| rst_req | output | 1 | Reset request, one-cycle pulse |
| rst_proc | output | 1 | Reset request is processor-only |

## Verification
The assertions check the following on every cycle:
- the counter never exceeds the configured reload value;
- the configuration no longer changes once it is locked;
- every reset pulse comes from a fault in the previous cycle, and `rst_proc` only appears with it;
- a disabled block raises no fault;
- a status read with no new fault leaves both flags clear;
- the interrupt only rises after a fault or a mode write.

Some properties can only be shown by the directed scenarios, because they depend on counting ticks:
- the exact timeout length for a given reload value;
- the window boundary, where a restart at a count equal to the delta is legal and one above it is an error;
- the rejection of bad keys;
- freezing by each halt source;
- the full-count timeout with the reset configuration.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
   localparam int REG_W    = 32;
   localparam int OFS_CTRL = 0;
   localparam int OFS_MODE = 4;
   localparam int OFS_STAT = 8;

   localparam int WDD_LSB  = 16;
   localparam int B_IRQ    = 12;
   localparam int B_RST    = 13;
   localparam int B_PROC   = 14;
   localparam int B_DIS    = 15;
   localparam int B_DBG    = 28;
   localparam int B_IDLE   = 29;

   localparam int KEY_LSB  = 24;
   localparam int B_RSTRT  = 0;

   typedef struct packed {
      logic err;
      logic uf;
   } wdt_evt_t;
endpackage

// File: rtl/winwdt_regs.sv
module winwdt_regs
   import winwdt_pkg::*;
#(
   parameter int        CNT_W  = 12,
   parameter int        AW     = 4,
   parameter logic [7:0] KEY   = 8'hA5,
   parameter bit        RD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   input  wdt_evt_t         evt,
   output logic [CNT_W-1:0] cfg_wdv,
   output logic [CNT_W-1:0] cfg_wdd,
   output logic             cfg_irq,
   output logic             cfg_rst,
   output logic             cfg_proc,
   output logic             cfg_dis,
   output logic             cfg_dbg,
   output logic             cfg_idle,
   output logic             mode_wr,
   output logic             mode_locked,
   output logic [CNT_W-1:0] load_val,
   output logic             restart,
   output logic             stat_rd,
   output logic [1:0]       flags
);
   localparam logic [CNT_W-1:0] ONES      = '1;
   localparam logic [REG_W-1:0] FIELD_CNT = REG_W'(ONES);
   localparam logic [REG_W-1:0] MODE_RST  = FIELD_CNT | (FIELD_CNT << WDD_LSB)
                                          | (REG_W'(1) << B_RST)
                                          | (REG_W'(1) << B_DBG)
                                          | (REG_W'(1) << B_IDLE);
   localparam logic [REG_W-1:0] MODE_MASK = FIELD_CNT | (FIELD_CNT << WDD_LSB)
                                          | (REG_W'(1) << B_IRQ)  | (REG_W'(1) << B_RST)
                                          | (REG_W'(1) << B_PROC) | (REG_W'(1) << B_DIS)
                                          | (REG_W'(1) << B_DBG)  | (REG_W'(1) << B_IDLE);

   logic [REG_W-1:0] mode_q;
   logic [1:0]       flags_q;
   logic             locked_q;
   logic             hit_ctrl, hit_mode, hit_stat;
   logic [REG_W-1:0] rd_mux;

   assign hit_ctrl = bus_sel && (bus_addr == AW'(OFS_CTRL));
   assign hit_mode = bus_sel && (bus_addr == AW'(OFS_MODE));
   assign hit_stat = bus_sel && (bus_addr == AW'(OFS_STAT));

   assign mode_wr  = hit_mode && bus_wr && !locked_q;
   assign restart  = hit_ctrl && bus_wr
                     && (bus_wdata[KEY_LSB +: 8] == KEY)
                     && bus_wdata[B_RSTRT];
   assign stat_rd  = hit_stat && !bus_wr;
   assign load_val = bus_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_RST;
         locked_q <= 1'b0;
      end else if (mode_wr) begin
         mode_q   <= bus_wdata & MODE_MASK;
         locked_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (stat_rd ? 2'b00 : flags_q) | {evt.err, evt.uf};
   end

   always_comb begin
      rd_mux = '0;
      if (bus_sel && !bus_wr) begin
         if (hit_mode)      rd_mux = mode_q;
         else if (hit_stat) rd_mux = {{(REG_W-2){1'b0}}, flags_q};
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         logic [REG_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_mux;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate

   assign cfg_wdv     = mode_q[CNT_W-1:0];
   assign cfg_wdd     = mode_q[WDD_LSB +: CNT_W];
   assign cfg_irq     = mode_q[B_IRQ];
   assign cfg_rst     = mode_q[B_RST];
   assign cfg_proc    = mode_q[B_PROC];
   assign cfg_dis     = mode_q[B_DIS];
   assign cfg_dbg     = mode_q[B_DBG];
   assign cfg_idle    = mode_q[B_IDLE];
   assign mode_locked = locked_q;
   assign flags       = flags_q;
endmodule

// File: rtl/winwdt_counter.sv
module winwdt_counter
   import winwdt_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             idle_in,
   input  logic             dbg_in,
   input  logic [CNT_W-1:0] cfg_wdv,
   input  logic [CNT_W-1:0] cfg_wdd,
   input  logic             cfg_dis,
   input  logic             cfg_idle,
   input  logic             cfg_dbg,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             restart,
   output wdt_evt_t         evt,
   output logic [CNT_W-1:0] cnt_val
);
   logic [CNT_W-1:0] cnt_q;
   logic             running, frozen, step;

   assign running = !cfg_dis;
   assign frozen  = (cfg_idle && idle_in) || (cfg_dbg && dbg_in);
   assign step    = running && tick && !frozen && !restart && !load;

   always_comb begin
      evt.err = running && restart && (cnt_q > cfg_wdd);
      evt.uf  = step && (cnt_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '1;
      else if (load)               cnt_q <= load_val;
      else if (running && restart) cnt_q <= cfg_wdv;
      else if (step)               cnt_q <= (cnt_q == '0) ? cfg_wdv : cnt_q - 1'b1;
   end

   assign cnt_val = cnt_q;
endmodule

// File: rtl/winwdt_fault.sv
module winwdt_fault
   import winwdt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  wdt_evt_t evt,
   input  logic [1:0] flags,
   input  logic     cfg_irq,
   input  logic     cfg_rst,
   input  logic     cfg_proc,
   output logic     fault_irq,
   output logic     rst_req,
   output logic     rst_proc
);
   logic fire;
   assign fire = (evt.uf || evt.err) && cfg_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         rst_proc <= 1'b0;
      end else begin
         rst_req  <= fire;
         rst_proc <= fire && cfg_proc;
      end
   end

   assign fault_irq = cfg_irq && (|flags);
endmodule

// File: rtl/winwdt.sv
module winwdt
   import winwdt_pkg::*;
#(
   parameter int         CNT_W  = 12,
   parameter int         AW     = 4,
   parameter logic [7:0] KEY    = 8'hA5,
   parameter bit         RD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             idle_in,
   input  logic             dbg_in,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             fault_irq,
   output logic             rst_req,
   output logic             rst_proc
);
   generate
      if (CNT_W < 2 || CNT_W > 12) begin : g_bad_cnt_w
         initial $fatal(1, "winwdt: CNT_W must lie in 2..12");
      end
      if (AW < 4) begin : g_bad_aw
         initial $fatal(1, "winwdt: AW must be at least 4");
      end
   endgenerate

   wdt_evt_t         evt;
   logic [CNT_W-1:0] cfg_wdv, cfg_wdd, load_val, cnt_val;
   logic             cfg_irq, cfg_rst, cfg_proc, cfg_dis, cfg_dbg, cfg_idle;
   logic             mode_wr, mode_locked, restart, stat_rd;
   logic [1:0]       flags;

   winwdt_regs #(.CNT_W(CNT_W), .AW(AW), .KEY(KEY), .RD_REG(RD_REG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt(evt),
      .cfg_wdv(cfg_wdv), .cfg_wdd(cfg_wdd), .cfg_irq(cfg_irq), .cfg_rst(cfg_rst),
      .cfg_proc(cfg_proc), .cfg_dis(cfg_dis), .cfg_dbg(cfg_dbg), .cfg_idle(cfg_idle),
      .mode_wr(mode_wr), .mode_locked(mode_locked), .load_val(load_val),
      .restart(restart), .stat_rd(stat_rd), .flags(flags)
   );

   winwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .idle_in(idle_in), .dbg_in(dbg_in),
      .cfg_wdv(cfg_wdv), .cfg_wdd(cfg_wdd), .cfg_dis(cfg_dis),
      .cfg_idle(cfg_idle), .cfg_dbg(cfg_dbg),
      .load(mode_wr), .load_val(load_val), .restart(restart),
      .evt(evt), .cnt_val(cnt_val)
   );

   winwdt_fault u_fault (
      .clk(clk), .rst_n(rst_n), .evt(evt), .flags(flags),
      .cfg_irq(cfg_irq), .cfg_rst(cfg_rst), .cfg_proc(cfg_proc),
      .fault_irq(fault_irq), .rst_req(rst_req), .rst_proc(rst_proc)
   );
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] cfg_wdv,
   input logic [CNT_W-1:0] cfg_wdd,
   input logic [5:0]       cfg_bits,
   input logic             cfg_dis,
   input logic             mode_locked,
   input logic             mode_wr,
   input logic             stat_rd,
   input logic [1:0]       flags,
   input logic             evt_uf,
   input logic             evt_err,
   input logic             fault_irq,
   input logic             rst_req,
   input logic             rst_proc
);
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_val <= cfg_wdv);

   p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_locked |=> ($stable(cfg_wdv) && $stable(cfg_wdd) && $stable(cfg_bits)));

   p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(evt_uf) || $past(evt_err)));

   p_proc_with_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_proc |-> rst_req);

   p_dis_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dis |-> !(evt_uf || evt_err));

   p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !evt_uf && !evt_err) |=> (flags == 2'b00));

   p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_irq) |-> ($past(evt_uf) || $past(evt_err) || $past(mode_wr)));
endmodule

bind winwdt winwdt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cfg_wdv(cfg_wdv), .cfg_wdd(cfg_wdd),
   .cfg_bits({cfg_irq, cfg_rst, cfg_proc, cfg_dis, cfg_dbg, cfg_idle}),
   .cfg_dis(cfg_dis), .mode_locked(mode_locked), .mode_wr(mode_wr),
   .stat_rd(stat_rd), .flags(flags), .evt_uf(evt.uf), .evt_err(evt.err),
   .fault_irq(fault_irq), .rst_req(rst_req), .rst_proc(rst_proc)
);

// File: tb/winwdt_tb.sv
module winwdt_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYC = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, idle_in = 1'b0, dbg_in = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fault_irq, rst_req, rst_proc;

   int n_checks = 0;
   int n_errors = 0;
   int pulses = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   winwdt u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .idle_in(idle_in), .dbg_in(dbg_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fault_irq(fault_irq), .rst_req(rst_req), .rst_proc(rst_proc)
   );

   always @(negedge clk) if (rst_req === 1'b1) pulses++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 0; idle_in = 0; dbg_in = 0; bus_sel = 0; bus_wr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      #1;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
      #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
      #1;
   endtask

   // Mode: reload 5, delta 2, irq, reset, proc-only, debug-halt
   localparam logic [31:0] CFG_A = 32'h1002_7005;

   task automatic t_reset_state();
      logic [31:0] d;
      do_reset();
      bus_read(4'h4, d); chk("R1 mode reset value", d, 32'h3FFF2FFF);
      bus_read(4'h8, d); chk("R1 status reset value", d, 0);
      chk("R1 outputs low", {29'b0, fault_irq, rst_req, rst_proc}, 0);
   endtask

   task automatic t_default_timeout();
      logic [31:0] d;
      int p0;
      p0 = pulses;
      ticks(4095);
      chk("R3 no fault before full count", pulses - p0, 0);
      ticks(1);
      chk("R8 reset pulse at full count", rst_req, 1);
      chk("R8 not processor-only by default", rst_proc, 0);
      chk("R7 irq stays off with enable clear", fault_irq, 0);
      bus_read(4'h8, d); chk("R6 underflow flag", d, 1);
   endtask

   task automatic t_write_once();
      logic [31:0] d;
      do_reset();
      bus_write(4'h4, CFG_A);
      bus_read(4'h4, d); chk("R2 first mode write taken", d, CFG_A);
      bus_write(4'h4, 32'h0000_8001);
      bus_read(4'h4, d); chk("R2 second mode write ignored", d, CFG_A);
   endtask

   task automatic t_underflow();
      logic [31:0] d;
      int p0;
      p0 = pulses;
      ticks(5);
      chk("R3 no fault before reload+1 ticks", pulses - p0, 0);
      chk("R7 irq low before fault", fault_irq, 0);
      ticks(1);
      chk("R3 underflow after reload+1 ticks", rst_req, 1);
      chk("R8 processor-only with reset", rst_proc, 1);
      chk("R7 irq on underflow", fault_irq, 1);
      @(negedge clk); #1;
      chk("R8 reset request is one cycle", rst_req, 0);
      chk("R6 flag sticky before read", fault_irq, 1);
      bus_read(4'h8, d); chk("R6 status underflow bit0", d, 1);
      chk("R7 irq drops after status read", fault_irq, 0);
      bus_read(4'h8, d); chk("R6 status cleared by read", d, 0);
   endtask

   task automatic t_early_restart();
      logic [31:0] d;
      bus_write(4'h0, 32'hA500_0001);
      chk("R5 early restart raises reset", rst_req, 1);
      bus_read(4'h8, d); chk("R5 early restart error bit1", d, 2);
   endtask

   task automatic t_bad_key();
      logic [31:0] d;
      int p0;
      p0 = pulses;
      bus_write(4'h0, 32'h5A00_0001);
      bus_write(4'h0, 32'hA500_0000);
      chk("R4 wrong key or no restart bit ignored", pulses - p0, 0);
      bus_read(4'h8, d); chk("R4 no error from ignored writes", d, 0);
   endtask

   task automatic t_legal_restart();
      logic [31:0] d;
      int p0;
      p0 = pulses;
      ticks(3);
      bus_write(4'h0, 32'hA500_0001);
      bus_read(4'h8, d); chk("R5 restart at delta is legal", d, 0);
      ticks(5);
      chk("R4 restart reloaded counter", pulses - p0, 0);
      ticks(1);
      chk("R4 timeout counted from restart", rst_req, 1);
      bus_read(4'h8, d); chk("R6 underflow after restart", d, 1);
   endtask

   task automatic t_halt();
      logic [31:0] d;
      int p0;
      p0 = pulses;
      dbg_in = 1;
      ticks(10);
      chk("R10 debug halt freezes counter", pulses - p0, 0);
      dbg_in = 0; idle_in = 1;
      ticks(5);
      chk("R10 idle without enable keeps counting", pulses - p0, 0);
      ticks(1);
      chk("R10 idle without enable reaches underflow", rst_req, 1);
      idle_in = 0;
      bus_read(4'h8, d);
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      int p0;
      do_reset();
      bus_write(4'h4, 32'h0002_B005);
      p0 = pulses;
      ticks(20);
      bus_write(4'h0, 32'hA500_0001);
      chk("R9 disabled raises no fault", pulses - p0, 0);
      bus_read(4'h8, d); chk("R9 disabled status stays clear", d, 0);
      chk("R9 disabled irq low", fault_irq, 0);
   endtask

   task automatic t_irq_only();
      logic [31:0] d;
      int p0;
      do_reset();
      bus_write(4'h4, 32'h0002_1002);
      p0 = pulses;
      bus_write(4'h0, 32'hA500_0001);
      chk("R5 restart at count equal to delta legal", fault_irq, 0);
      ticks(2);
      chk("R3 no irq before timeout", fault_irq, 0);
      ticks(1);
      chk("R7 irq on underflow", fault_irq, 1);
      chk("R8 no reset pulse with enable clear", pulses - p0, 0);
      bus_read(4'h8, d); chk("R6 underflow flag irq-only", d, 1);
   endtask

   task automatic run_all();
      t_reset_state();
      t_default_timeout();
      t_write_once();
      t_underflow();
      t_early_restart();
      t_bad_key();
      t_legal_restart();
      t_halt();
      t_disabled();
      t_irq_only();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (WATCHDOG_CYC) @(posedge clk);
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule